// File: doc/BRIEF.md
# SDRAM Multi-Bank Command Legality Monitor

This block sits beside a single-data-rate SDRAM command bus and observes every command that a controller issues. It keeps a small timed state machine for each bank. From that state it decides whether each command may be issued. For every command it either updates the affected bank or banks, or raises a one-cycle violation flag with a code that names the broken rule. The monitor never drives the bus. It is meant for simulation benches and for on-chip debug alongside a memory controller.

Each bank's state is published as a 3-bit field, so that a bench or a trace buffer can follow row opening, bursts, auto-precharge and precharge. Timing windows are counted in clocks: row-to-column delay, precharge time and burst length are all parameters. Analog timing and the data path are not checked.

Top module: `sdr_cmd_guard`

## Requirements
- R1: A command is evaluated only when CKE was high at the previous clock edge and is high at the current edge (self-refresh entry excepted, see R7). Otherwise it causes no violation and no command-driven bank change, while running bank timers keep counting.
- R2: With CS_n high, or with the NOP code ({ras_n,cas_n,we_n} = 3'b111), no bank changes apart from timer expiry and no violation is raised.
- R3: ACTIVE (3'b011) to an Idle bank moves it to Activating for T_RCD clocks and then to Row Active. ACTIVE to any bank that is not Idle raises code 1 and changes nothing.
- R4: READ (3'b101) or WRITE (3'b100) with A10 low, sent to a bank in Row Active, Read or Write, puts it in Read or Write for BURST_LEN clocks and then back to Row Active. A READ or WRITE to a bank in any other state raises code 2.
- R5: READ or WRITE with A10 high puts the bank in Read-auto-precharge or Write-auto-precharge for BURST_LEN+T_RP clocks, after which it is Idle. The same legality as R4 applies.
- R6: PRECHARGE (3'b010) targets the BA bank when A10 is low and every bank when A10 is high. Each target moves to Precharging for T_RP clocks and then to Idle. If any target is Activating or in an auto-precharge state, the command raises code 3 and changes nothing.
- R7: AUTO REFRESH (3'b001), LOAD MODE (3'b000) and self-refresh entry (AUTO REFRESH with CKE high at the previous edge and low at the current one) are legal only when every bank is Idle. Otherwise they raise code 4. They never change bank state.
- R8: BURST TERMINATE (3'b110) is legal only when the BA bank is in Read or Write without auto-precharge, and that bank returns to Row Active at the next edge. In every other case it raises code 5.
- R9: `viol` goes high for exactly the clock after the edge that sampled an illegal command, with `viol_code` holding the code. `viol_code` is 0 whenever `viol` is low, and an illegal command changes no bank.
- R10: After reset every bank reads Idle and `viol` is low. State codes are Idle 0, Activating 1, Row Active 2, Read 3, Write 4, Read-auto-precharge 5, Write-auto-precharge 6, Precharging 7, and bank b sits at `bank_state[3b+2:3b]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| bank_state | output | 3*2^BA_W | Registered per-bank state codes |
| viol | output | 1 | Registered violation pulse |
| viol_code | output | 3 | Registered code of the broken rule |

## Verification
A bank tracker holding the wrong state, or a timer loaded with the wrong count, shows up directly in that bank's `bank_state` field on the clock after the faulty edge. That makes early or late expiry visible to within one cycle. A wrong state that survives also changes the legality of the next command to that bank, so it reappears as a missing or spurious `viol` pulse one clock after that command. The bench drives long mixed command streams over a short-timer configuration and compares all bank fields and both violation outputs with an arithmetic model every cycle.

// File: rtl/sdr_guard_pkg.sv
package sdr_guard_pkg;

  // Per-bank state; the numeric values are visible on the bank_state port.
  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_RD      = 3'd3,
    BK_WR      = 3'd4,
    BK_RD_AP   = 3'd5,
    BK_WR_AP   = 3'd6,
    BK_CLOSING = 3'd7
  } bank_st_e;

  // Command code equals {ras_n, cas_n, we_n}.
  typedef enum logic [2:0] {
    OP_LMR = 3'd0,
    OP_REF = 3'd1,
    OP_PRE = 3'd2,
    OP_ACT = 3'd3,
    OP_WR  = 3'd4,
    OP_RD  = 3'd5,
    OP_BST = 3'd6,
    OP_NOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    EC_NONE     = 3'd0,
    EC_ACT_BUSY = 3'd1,
    EC_NO_ROW   = 3'd2,
    EC_PRE_BUSY = 3'd3,
    EC_NOT_IDLE = 3'd4,
    EC_BST_BANK = 3'd5
  } err_e;

  // Action applied to one bank tracker at the next edge.
  typedef enum logic [2:0] {
    BA_NONE,
    BA_OPEN,
    BA_RD,
    BA_WR,
    BA_RD_AP,
    BA_WR_AP,
    BA_CLOSE,
    BA_STOP
  } bank_act_e;

endpackage

// File: rtl/sdr_op_decode.sv
module sdr_op_decode
  import sdr_guard_pkg::*;
(
  input  logic cke,
  input  logic cke_d1,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op,
  output logic eval,
  output logic sr_entry
);

  always_comb begin
    op       = op_e'({ras_n, cas_n, we_n});
    eval     = cke_d1 & cke & ~cs_n;
    sr_entry = cke_d1 & ~cke & ~cs_n & (op == OP_REF);
  end

endmodule

// File: rtl/sdr_rule_check.sv
module sdr_rule_check
  import sdr_guard_pkg::*;
#(
  parameter int BA_W = 2,
  localparam int NB  = 1 << BA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eval,
  input  logic                 sr_entry,
  input  op_e                  op,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  bank_st_e [NB-1:0]    st,
  output bank_act_e [NB-1:0]   act,
  output err_e                 code
);

  logic     all_idle;
  logic     any_locked;
  bank_st_e tgt;

  always_comb begin
    all_idle   = 1'b1;
    any_locked = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (st[i] != BK_IDLE) all_idle = 1'b0;
      if (st[i] == BK_OPENING || st[i] == BK_RD_AP || st[i] == BK_WR_AP)
        any_locked = 1'b1;
    end
  end

  assign tgt = st[ba];

  always_comb begin
    code = EC_NONE;
    for (int i = 0; i < NB; i++) act[i] = BA_NONE;
    if (sr_entry) begin
      if (!all_idle) code = EC_NOT_IDLE;
    end else if (eval) begin
      unique case (op)
        OP_ACT: begin
          if (tgt == BK_IDLE) act[ba] = BA_OPEN;
          else                code    = EC_ACT_BUSY;
        end
        OP_RD, OP_WR: begin
          if (tgt == BK_OPEN || tgt == BK_RD || tgt == BK_WR) begin
            if (op == OP_RD) act[ba] = a10 ? BA_RD_AP : BA_RD;
            else             act[ba] = a10 ? BA_WR_AP : BA_WR;
          end else begin
            code = EC_NO_ROW;
          end
        end
        OP_PRE: begin
          if (a10) begin
            if (any_locked) code = EC_PRE_BUSY;
            else for (int i = 0; i < NB; i++) act[i] = BA_CLOSE;
          end else if (tgt == BK_OPENING || tgt == BK_RD_AP || tgt == BK_WR_AP) begin
            code = EC_PRE_BUSY;
          end else begin
            act[ba] = BA_CLOSE;
          end
        end
        OP_REF, OP_LMR: begin
          if (!all_idle) code = EC_NOT_IDLE;
        end
        OP_BST: begin
          if (tgt == BK_RD || tgt == BK_WR) act[ba] = BA_STOP;
          else                              code    = EC_BST_BANK;
        end
        default: ;
      endcase
    end
  end

  logic [NB-1:0] act_mask;
  always_comb
    for (int i = 0; i < NB; i++) act_mask[i] = (act[i] != BA_NONE);

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(op == OP_PRE && a10) |-> $countones(act_mask) <= 1); // R4

  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (rst)
    (code != EC_NONE) |-> (act_mask == '0)); // R9

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_guard_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  localparam int AP_SPAN  = BURST_LEN + T_RP,
  localparam int CW       = $clog2(AP_SPAN + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  bank_act_e act,
  output bank_st_e  st
);

  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_BL  = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] LD_AP  = CW'(AP_SPAN - 1);

  logic [CW-1:0] cnt;
  logic          timed;
  bank_st_e      expire_to;

  always_comb begin
    timed     = 1'b1;
    expire_to = BK_IDLE;
    unique case (st)
      BK_OPENING, BK_RD, BK_WR: expire_to = BK_OPEN;
      BK_RD_AP, BK_WR_AP, BK_CLOSING: expire_to = BK_IDLE;
      default: timed = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else begin
      unique case (act)
        BA_OPEN:  begin st <= BK_OPENING; cnt <= LD_RCD; end
        BA_RD:    begin st <= BK_RD;      cnt <= LD_BL;  end
        BA_WR:    begin st <= BK_WR;      cnt <= LD_BL;  end
        BA_RD_AP: begin st <= BK_RD_AP;   cnt <= LD_AP;  end
        BA_WR_AP: begin st <= BK_WR_AP;   cnt <= LD_AP;  end
        BA_CLOSE: begin st <= BK_CLOSING; cnt <= LD_RP;  end
        BA_STOP:  begin st <= BK_OPEN;    cnt <= '0;     end
        default: begin
          if (timed) begin
            if (cnt == '0) st  <= expire_to;
            else           cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  logic pv;
  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (pv && st == BK_IDLE && $past(st) != BK_IDLE) |->
      ($past(st) == BK_CLOSING || $past(st) == BK_RD_AP || $past(st) == BK_WR_AP)); // R6

  AST_OPEN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (pv && st == BK_OPEN && $past(st) != BK_OPEN) |->
      ($past(st) == BK_OPENING || $past(st) == BK_RD || $past(st) == BK_WR)); // R4

endmodule

// File: rtl/sdr_cmd_guard.sv
module sdr_cmd_guard
  import sdr_guard_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4,
  localparam int NB       = 1 << BA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  output logic [3*NB-1:0]   bank_state,
  output logic              viol,
  output logic [2:0]        viol_code
);

  logic                cke_d1;
  op_e                 op;
  logic                eval;
  logic                sr_entry;
  bank_st_e [NB-1:0]   st;
  bank_act_e [NB-1:0]  act;
  err_e                code;
  err_e                code_q;

  always_ff @(posedge clk) begin
    if (rst) cke_d1 <= 1'b0;
    else     cke_d1 <= cke;
  end

  sdr_op_decode u_dec (
    .cke      (cke),
    .cke_d1   (cke_d1),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .op       (op),
    .eval     (eval),
    .sr_entry (sr_entry)
  );

  sdr_rule_check #(.BA_W(BA_W)) u_rules (
    .clk      (clk),
    .rst      (rst),
    .eval     (eval),
    .sr_entry (sr_entry),
    .op       (op),
    .ba       (ba),
    .a10      (a10),
    .st       (st),
    .act      (act),
    .code     (code)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdr_bank_track #(
      .T_RCD     (T_RCD),
      .T_RP      (T_RP),
      .BURST_LEN (BURST_LEN)
    ) u_trk (
      .clk (clk),
      .rst (rst),
      .act (act[g]),
      .st  (st[g])
    );
    assign bank_state[3*g +: 3] = st[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol   <= 1'b0;
      code_q <= EC_NONE;
    end else begin
      viol   <= (code != EC_NONE);
      code_q <= code;
    end
  end

  assign viol_code = code_q;

  logic all_idle;
  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NB; i++) if (st[i] != BK_IDLE) all_idle = 1'b0;
  end

  logic pv;
  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  AST_CKE_GATE: assert property (@(posedge clk) disable iff (rst)
    (pv && viol) |-> $past(cke_d1)); // R1

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (eval && op == OP_NOP) |=> !viol); // R2

  AST_ACT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (eval && op == OP_ACT && st[ba] != BK_IDLE) |=> (viol && viol_code == 3'd1)); // R3

  AST_REF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (eval && (op == OP_REF || op == OP_LMR) && !all_idle) |=>
      (viol && viol_code == 3'd4)); // R7

endmodule

// File: tb/sdr_cmd_guard_tb_top.sv
module sdr_cmd_guard_tb_top;

  localparam int RCD = 2;
  localparam int RP  = 3;
  localparam int BL  = 2;
  localparam int NB  = 4;

  localparam int C_LMR = 0, C_REF = 1, C_PRE = 2, C_ACT = 3;
  localparam int C_WR  = 4, C_RD  = 5, C_BST = 6, C_NOP = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [3*NB-1:0] bank_state;
  logic viol;
  logic [2:0] viol_code;

  always #4 clk = ~clk;

  sdr_cmd_guard #(.BA_W(2), .T_RCD(RCD), .T_RP(RP), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .bank_state(bank_state), .viol(viol), .viol_code(viol_code)
  );

  int checks = 0;
  int errors = 0;
  int mst[NB];
  int mcnt[NB];
  int exp_code = 0;
  bit mcke_d1 = 1'b0;
  string lbl = "R10";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic model_step(input bit k, input bit c, input int op,
                            input int b, input bit ap);
    int nact[NB];
    bit allidle = 1'b1;
    bit locked = 1'b0;
    bit ev, sre;
    int t, ec;
    ec = 0;
    for (int i = 0; i < NB; i++) begin
      nact[i] = 0;
      if (mst[i] != 0) allidle = 1'b0;
      if (mst[i] == 1 || mst[i] == 5 || mst[i] == 6) locked = 1'b1;
    end
    ev  = mcke_d1 && k && !c;
    sre = mcke_d1 && !k && !c && op == C_REF;
    t   = mst[b];
    if (sre) begin
      lbl = "R7";
      if (!allidle) ec = 4;
    end else if (!(mcke_d1 && k)) lbl = "R1";
    else if (c || op == C_NOP) lbl = "R2";
    else begin
      case (op)
        C_ACT: begin lbl = "R3"; if (t == 0) nact[b] = 1; else ec = 1; end
        C_RD, C_WR: begin
          lbl = ap ? "R5" : "R4";
          if (t == 2 || t == 3 || t == 4)
            nact[b] = (op == C_RD) ? (ap ? 4 : 2) : (ap ? 5 : 3);
          else ec = 2;
        end
        C_PRE: begin
          lbl = "R6";
          if (ap) begin
            if (locked) ec = 3;
            else for (int i = 0; i < NB; i++) nact[i] = 6;
          end else if (t == 1 || t == 5 || t == 6) ec = 3;
          else nact[b] = 6;
        end
        C_REF, C_LMR: begin lbl = "R7"; if (!allidle) ec = 4; end
        C_BST: begin lbl = "R8"; if (t == 3 || t == 4) nact[b] = 7; else ec = 5; end
        default: ;
      endcase
    end
    for (int i = 0; i < NB; i++) begin
      case (nact[i])
        1: begin mst[i] = 1; mcnt[i] = RCD - 1; end
        2: begin mst[i] = 3; mcnt[i] = BL - 1; end
        3: begin mst[i] = 4; mcnt[i] = BL - 1; end
        4: begin mst[i] = 5; mcnt[i] = BL + RP - 1; end
        5: begin mst[i] = 6; mcnt[i] = BL + RP - 1; end
        6: begin mst[i] = 7; mcnt[i] = RP - 1; end
        7: begin mst[i] = 2; mcnt[i] = 0; end
        default: begin
          if (mst[i] != 0 && mst[i] != 2) begin
            if (mcnt[i] == 0) mst[i] = (mst[i] == 1 || mst[i] == 3 || mst[i] == 4) ? 2 : 0;
            else mcnt[i] = mcnt[i] - 1;
          end
        end
      endcase
    end
    exp_code = ec;
    mcke_d1  = k;
  endtask

  task automatic compare_all();
    for (int i = 0; i < NB; i++)
      chk(int'(bank_state[3*i +: 3]) == mst[i], lbl, $sformatf("bank%0d state", i),
          int'(bank_state[3*i +: 3]), mst[i]);
    chk(int'(viol) == int'(exp_code != 0), lbl, "viol", int'(viol), int'(exp_code != 0));
    chk(int'(viol_code) == exp_code, lbl, "viol_code", int'(viol_code), exp_code);
    chk(viol || viol_code == 3'd0, "R9", "code without viol", int'(viol_code), 0);
  endtask

  task automatic cyc(input bit k, input bit c, input int op, input int b, input bit ap);
    cke = k; cs_n = c;
    {ras_n, cas_n, we_n} = 3'(op);
    ba = 2'(b); a10 = ap;
    model_step(k, c, op, b, ap);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, C_NOP, 0, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mst[i] = 0; mcnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    for (int i = 0; i < NB; i++)
      chk(bank_state[3*i +: 3] == 3'd0, "R10", "reset state", int'(bank_state[3*i +: 3]), 0);
    chk(!viol, "R10", "reset viol", int'(viol), 0);
    rst = 1'b0;
    mcke_d1 = 1'b0;
    lbl = "R1";
    cyc(1'b1, 1'b0, C_ACT, 0, 1'b0);   // first edge: previous CKE still reset-low, R1
    idle_n(2);
    // R3 open, busy activate, R4 read, R8 terminate
    cyc(1'b1, 1'b0, C_ACT, 0, 1'b0);
    cyc(1'b1, 1'b0, C_ACT, 0, 1'b0);
    cyc(1'b1, 1'b0, C_RD, 0, 1'b0);
    idle_n(1);
    cyc(1'b1, 1'b0, C_RD, 0, 1'b0);
    cyc(1'b1, 1'b0, C_BST, 1, 1'b0);
    cyc(1'b1, 1'b0, C_BST, 0, 1'b0);
    cyc(1'b1, 1'b0, C_REF, 0, 1'b0);
    cyc(1'b1, 1'b0, C_WR, 0, 1'b1);
    cyc(1'b1, 1'b0, C_PRE, 0, 1'b0);
    cyc(1'b1, 1'b0, C_PRE, 1, 1'b1);
    idle_n(BL + RP + 1);
    cyc(1'b1, 1'b0, C_LMR, 0, 1'b0);
    cyc(1'b1, 1'b0, C_REF, 0, 1'b0);
    cyc(1'b0, 1'b0, C_REF, 0, 1'b0);   // self-refresh entry while idle
    cyc(1'b1, 1'b0, C_ACT, 2, 1'b0);   // R1: previous CKE low
    cyc(1'b1, 1'b0, C_ACT, 2, 1'b0);
    cyc(1'b1, 1'b1, C_PRE, 2, 1'b1);   // R2: deselected
    cyc(1'b0, 1'b0, C_REF, 0, 1'b0);   // self-refresh entry with open bank
    cyc(1'b1, 1'b0, C_RD, 3, 1'b0);
    idle_n(4);
    for (int n = 0; n < 6000; n++) begin
      bit k, c, ap;
      int op, b;
      k  = ($urandom % 16) != 0;
      c  = ($urandom % 10) == 0;
      op = (($urandom % 4) == 0) ? C_NOP : int'($urandom % 8);
      b  = int'($urandom % 4);
      ap = ($urandom % 3) == 0;
      cyc(k, c, op, b, ap);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule